// File: doc/BRIEF.md
# Vectored Interrupt Priority Controller

This block keeps the per-vector pending, in-service and trigger-type state for a single processor's local interrupt controller, covering 256 vectors. Vectors arrive already routed to this processor, each with a flag that marks it level or edge triggered. The block derives a processor priority from a programmable task priority and the highest vector now in service. It raises an interrupt line while some pending vector sits in a higher 16-vector class than that priority.

The processor claims an interrupt by pulsing an acknowledge. One cycle later the block answers with one of three results. It returns the winning vector and moves it from pending to in service. If a request is pending but blocked, it returns the programmed spurious vector. Otherwise it reports that no interrupt is present. An end-of-interrupt pulse retires the highest in-service vector. When that vector was level triggered, the block sends a one-cycle broadcast carrying the vector, so the upstream source can re-sample its line. A control bit suppresses this broadcast.

Top module: `vec_prio_ctrl`

## Requirements
- R1: After reset, no vector is pending, in service or marked level. The task priority is 0. The unit is disabled, the spurious vector is 8'hFF and broadcast suppression is off. irq_o, ack_done_o and eoi_bcast_o are 0.
- R2: A request marks its vector pending. It records the vector as level triggered when req_level_i=1 and as edge triggered when req_level_i=0, and a later request for the same vector overwrites that record.
- R3: Where several vectors are pending or in service, the highest-numbered one is the top of its set.
- R4: The processor priority equals the task priority when task_priority[7:4] >= class[7:4] of the top in-service vector, where an empty in-service set counts as vector 0. Otherwise it is {that class, 4'h0}.
- R5: irq_o is registered. It is 1 in the cycle after a state in which three things hold: the unit is enabled, some vector is pending, and either the processor priority is 0 or the class of the top pending vector is above the processor priority's class.
- R6: An acknowledge when irq_o's condition holds answers with ack_done_o=1, ack_kind_o=2'b01 and the top pending vector in the next cycle. That vector moves from pending to in service.
- R7: An acknowledge while enabled with a pending but blocked vector answers with ack_kind_o=2'b10 and the spurious vector. The pending set is left unchanged.
- R8: An acknowledge with nothing pending, or while disabled, answers with ack_kind_o=2'b00 and vector 0.
- R9: End-of-interrupt clears the top in-service vector. With an empty in-service set it has no effect.
- R10: When the retired vector is marked level and suppression is off, eoi_bcast_o pulses for one cycle in the next cycle, with eoi_bcast_vec_o set to the vector. Otherwise eoi_bcast_o stays 0.
- R11: A control write takes the spurious vector from data[7:0], the enable from data[8] and broadcast suppression from data[12]. All other data bits are ignored.
- R12: In one cycle, the acknowledge is applied first. End-of-interrupt then retires the top of the in-service set that includes the newly acknowledged vector. A new request sets its pending bit after the acknowledge has cleared it. Task priority and control writes take effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Incoming vector strobe |
| req_vec_i | input | 8 | Incoming vector number |
| req_level_i | input | 1 | 1 = level triggered, 0 = edge |
| tpr_wr_i | input | 1 | Task priority write strobe |
| tpr_data_i | input | 8 | Task priority value |
| ctl_wr_i | input | 1 | Control write strobe |
| ctl_data_i | input | 32 | Control value (fields per R11) |
| ack_req_i | input | 1 | Interrupt acknowledge pulse |
| eoi_wr_i | input | 1 | End-of-interrupt pulse |
| irq_o | output | 1 | Interrupt request to the processor |
| ack_done_o | output | 1 | Acknowledge answer valid |
| ack_kind_o | output | 2 | 00 none, 01 vector, 10 spurious |
| ack_vec_o | output | 8 | Answered vector |
| eoi_bcast_o | output | 1 | Level-vector retirement broadcast |
| eoi_bcast_vec_o | output | 8 | Vector carried by the broadcast |

## Verification
The assertions check several rules on every cycle. Pending bits appear only through requests, and in-service bits drop only on end-of-interrupt. A returned vector is in service. A raised line implies the unit was enabled, and a broadcast implies suppression was off. Each encoder index also points at a set bit. Only the scenarios can show the ordering itself. These cover masking by task-priority class, one vector both pending and in service, and the retirement order of nested vectors. They also cover acknowledge and end-of-interrupt in one cycle and the overwrite of the trigger type. A behavioural model in the bench checks each of these on every clock.

// File: rtl/vpc_pkg.sv
package vpc_pkg;
  localparam int CLS_W        = 4;
  localparam int CTL_W        = 32;
  localparam int CTL_EN_BIT   = 8;
  localparam int CTL_SUPP_BIT = 12;

  typedef enum logic [1:0] {
    ACK_NONE = 2'b00,
    ACK_VEC  = 2'b01,
    ACK_SPUR = 2'b10
  } ack_kind_t;
endpackage

// File: rtl/vpc_top_find.sv
module vpc_top_find #(
  parameter int WIDTH    = 256,
  parameter int SEG_BITS = 32
) (
  input  logic [WIDTH-1:0]         bits_i,
  output logic                     hit_o,
  output logic [$clog2(WIDTH)-1:0] idx_o
);
  localparam int NSEG  = WIDTH / SEG_BITS;
  localparam int SEG_W = $clog2(SEG_BITS);
  localparam int IDX_W = $clog2(WIDTH);

  logic [NSEG-1:0]  seg_hit;
  logic [SEG_W-1:0] seg_idx [NSEG];

  // first stage: one highest-bit search per segment
  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    logic [SEG_W-1:0] loc;
    always_comb begin
      loc = '0;
      for (int b = 0; b < SEG_BITS; b++) begin
        if (bits_i[g*SEG_BITS + b]) loc = SEG_W'(b);
      end
    end
    assign seg_hit[g] = |bits_i[g*SEG_BITS +: SEG_BITS];
    assign seg_idx[g] = loc;
  end

  // second stage: highest non-empty segment wins
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int s = 0; s < NSEG; s++) begin
      if (seg_hit[s]) begin
        hit_o = 1'b1;
        idx_o = IDX_W'(s * SEG_BITS) | IDX_W'(seg_idx[s]);
      end
    end
  end

  // R3: a reported index always names a set bit
  always_comb begin
    if (hit_o) a_r3_idx_is_set: assert (bits_i[idx_o]);
  end
endmodule

// File: rtl/vpc_prio_eval.sv
module vpc_prio_eval
  import vpc_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic             en_i,
  input  logic             irr_hit_i,
  input  logic [CLS_W-1:0] irr_cls_i,
  input  logic             isr_hit_i,
  input  logic [CLS_W-1:0] isr_cls_i,
  input  logic [VEC_W-1:0] tpr_i,
  output logic             grant_o,
  output logic             blocked_o
);
  localparam int LOW_W = VEC_W - CLS_W;

  logic [CLS_W-1:0] svc_cls;
  logic [VEC_W-1:0] ppr;
  logic             masked;

  always_comb begin
    svc_cls = isr_hit_i ? isr_cls_i : '0;
    if (tpr_i[VEC_W-1 -: CLS_W] >= svc_cls) ppr = tpr_i;
    else                                   ppr = {svc_cls, {LOW_W{1'b0}}};
    masked    = (ppr != '0) && (irr_cls_i <= ppr[VEC_W-1 -: CLS_W]);
    grant_o   = en_i && irr_hit_i && !masked;
    blocked_o = en_i && irr_hit_i && masked;
  end
endmodule

// File: rtl/vpc_vec_store.sv
module vpc_vec_store #(
  parameter int NUM_VEC = 256,
  parameter int VEC_W   = 8
) (
  input  logic               clk,
  input  logic               rst_ni,
  input  logic               req_en_i,
  input  logic [VEC_W-1:0]   req_vec_i,
  input  logic               req_level_i,
  input  logic               take_en_i,
  input  logic [VEC_W-1:0]   take_vec_i,
  input  logic               retire_en_i,
  input  logic [VEC_W-1:0]   retire_vec_i,
  output logic [NUM_VEC-1:0] irr_o,
  output logic [NUM_VEC-1:0] isr_o,
  output logic [NUM_VEC-1:0] tmr_o
);
  logic [NUM_VEC-1:0] irr_q, irr_n, isr_q, isr_n, tmr_q, tmr_n;
  logic               irr_ce, isr_ce, tmr_ce;

  always_comb begin
    irr_n = irr_q;
    isr_n = isr_q;
    tmr_n = tmr_q;
    if (take_en_i) begin
      irr_n[take_vec_i] = 1'b0;
      isr_n[take_vec_i] = 1'b1;
    end
    if (req_en_i) begin
      irr_n[req_vec_i] = 1'b1;
      tmr_n[req_vec_i] = req_level_i;
    end
    if (retire_en_i) isr_n[retire_vec_i] = 1'b0;
    irr_ce = req_en_i | take_en_i;
    isr_ce = take_en_i | retire_en_i;
    tmr_ce = req_en_i;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      irr_q <= '0;
      isr_q <= '0;
      tmr_q <= '0;
    end else begin
      if (irr_ce) irr_q <= irr_n;
      if (isr_ce) isr_q <= isr_n;
      if (tmr_ce) tmr_q <= tmr_n;
    end
  end

  assign irr_o = irr_q;
  assign isr_o = isr_q;
  assign tmr_o = tmr_q;

  // R9: an in-service bit only drops on a retirement
  a_r9_isr_drop_needs_eoi: assert property (@(posedge clk) disable iff (!rst_ni)
    !$past(retire_en_i) |-> ((~isr_q & $past(isr_q)) == '0));

  // R2: a pending bit only appears through a request
  a_r2_irr_rise_needs_req: assert property (@(posedge clk) disable iff (!rst_ni)
    !$past(req_en_i) |-> ((irr_q & ~$past(irr_q)) == '0));
endmodule

// File: rtl/vec_prio_ctrl.sv
module vec_prio_ctrl
  import vpc_pkg::*;
#(
  parameter int NUM_VEC  = 256,
  parameter int SEG_BITS = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid_i,
  input  logic [$clog2(NUM_VEC)-1:0] req_vec_i,
  input  logic                       req_level_i,
  input  logic                       tpr_wr_i,
  input  logic [$clog2(NUM_VEC)-1:0] tpr_data_i,
  input  logic                       ctl_wr_i,
  input  logic [31:0]                ctl_data_i,
  input  logic                       ack_req_i,
  input  logic                       eoi_wr_i,
  output logic                       irq_o,
  output logic                       ack_done_o,
  output logic [1:0]                 ack_kind_o,
  output logic [$clog2(NUM_VEC)-1:0] ack_vec_o,
  output logic                       eoi_bcast_o,
  output logic [$clog2(NUM_VEC)-1:0] eoi_bcast_vec_o
);
  localparam int VEC_W = $clog2(NUM_VEC);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // programmable state
  logic [VEC_W-1:0] tpr_q, spur_vec_q;
  logic             en_q, supp_q;
  logic             unused_ctl;
  assign unused_ctl = ^{ctl_data_i[CTL_W-1:CTL_SUPP_BIT+1],
                        ctl_data_i[CTL_SUPP_BIT-1:CTL_EN_BIT+1]};

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      tpr_q      <= '0;
      spur_vec_q <= '1;
      en_q       <= 1'b0;
      supp_q     <= 1'b0;
    end else begin
      if (tpr_wr_i) tpr_q <= tpr_data_i;
      if (ctl_wr_i) begin
        spur_vec_q <= ctl_data_i[VEC_W-1:0];
        en_q       <= ctl_data_i[CTL_EN_BIT];
        supp_q     <= ctl_data_i[CTL_SUPP_BIT];
      end
    end
  end

  // vector arrays and their top-of-set encoders
  logic [NUM_VEC-1:0] irr, isr, tmr;
  logic               irr_hit, isr_hit;
  logic [VEC_W-1:0]   irr_top, isr_top;
  logic               grant, blocked;
  logic               ack_take, retire_en;
  logic [VEC_W-1:0]   retire_vec;

  vpc_top_find #(.WIDTH(NUM_VEC), .SEG_BITS(SEG_BITS)) u_find_irr (
    .bits_i(irr), .hit_o(irr_hit), .idx_o(irr_top));
  vpc_top_find #(.WIDTH(NUM_VEC), .SEG_BITS(SEG_BITS)) u_find_isr (
    .bits_i(isr), .hit_o(isr_hit), .idx_o(isr_top));

  vpc_prio_eval #(.VEC_W(VEC_W)) u_prio (
    .en_i      (en_q),
    .irr_hit_i (irr_hit),
    .irr_cls_i (irr_top[VEC_W-1 -: CLS_W]),
    .isr_hit_i (isr_hit),
    .isr_cls_i (isr_top[VEC_W-1 -: CLS_W]),
    .tpr_i     (tpr_q),
    .grant_o   (grant),
    .blocked_o (blocked));

  // acknowledge first, then retire from the set that includes it
  always_comb begin
    ack_take   = ack_req_i && grant;
    retire_en  = eoi_wr_i && (isr_hit || ack_take);
    retire_vec = (ack_take && (!isr_hit || irr_top > isr_top)) ? irr_top : isr_top;
  end

  vpc_vec_store #(.NUM_VEC(NUM_VEC), .VEC_W(VEC_W)) u_store (
    .clk          (clk),
    .rst_ni       (rst_int_n),
    .req_en_i     (req_valid_i),
    .req_vec_i    (req_vec_i),
    .req_level_i  (req_level_i),
    .take_en_i    (ack_take),
    .take_vec_i   (irr_top),
    .retire_en_i  (retire_en),
    .retire_vec_i (retire_vec),
    .irr_o        (irr),
    .isr_o        (isr),
    .tmr_o        (tmr));

  // response next state
  ack_kind_t        kind_n;
  logic [VEC_W-1:0] ack_vec_n, bc_vec_n;
  logic             bc_n;

  always_comb begin
    kind_n    = ACK_NONE;
    ack_vec_n = '0;
    if (ack_req_i && grant) begin
      kind_n    = ACK_VEC;
      ack_vec_n = irr_top;
    end else if (ack_req_i && blocked) begin
      kind_n    = ACK_SPUR;
      ack_vec_n = spur_vec_q;
    end
    bc_n     = retire_en && tmr[retire_vec] && !supp_q;
    bc_vec_n = bc_n ? retire_vec : '0;
  end

  ack_kind_t kind_q;
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      irq_o           <= 1'b0;
      ack_done_o      <= 1'b0;
      kind_q          <= ACK_NONE;
      ack_vec_o       <= '0;
      eoi_bcast_o     <= 1'b0;
      eoi_bcast_vec_o <= '0;
    end else begin
      irq_o           <= grant;
      ack_done_o      <= ack_req_i;
      kind_q          <= kind_n;
      ack_vec_o       <= ack_vec_n;
      eoi_bcast_o     <= bc_n;
      eoi_bcast_vec_o <= bc_vec_n;
    end
  end
  assign ack_kind_o = kind_q;

  // R5: the line is only raised out of an enabled state
  a_r5_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_int_n)
    irq_o |-> $past(en_q));

  // R6: a returned vector is in service unless retired in the same cycle
  a_r6_ack_vec_in_service: assert property (@(posedge clk) disable iff (!rst_int_n)
    (kind_q == ACK_VEC && !$past(eoi_wr_i)) |-> isr[ack_vec_o]);

  // R7: a spurious answer leaves the pending set non-empty
  a_r7_spur_keeps_pending: assert property (@(posedge clk) disable iff (!rst_int_n)
    (kind_q == ACK_SPUR) |-> (irr != '0));

  // R10: no broadcast while suppression was on
  a_r10_bcast_not_suppressed: assert property (@(posedge clk) disable iff (!rst_int_n)
    eoi_bcast_o |-> !$past(supp_q));

  // R8: an answer only follows an acknowledge
  a_r8_answer_needs_ack: assert property (@(posedge clk) disable iff (!rst_int_n)
    ack_done_o |-> $past(ack_req_i));
endmodule

// File: tb/vec_prio_ctrl_test.sv
module vec_prio_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [7:0]  req_vec_i = '0;
  logic        req_level_i = 1'b0;
  logic        tpr_wr_i = 1'b0;
  logic [7:0]  tpr_data_i = '0;
  logic        ctl_wr_i = 1'b0;
  logic [31:0] ctl_data_i = '0;
  logic        ack_req_i = 1'b0;
  logic        eoi_wr_i = 1'b0;
  logic        irq_o, ack_done_o, eoi_bcast_o;
  logic [1:0]  ack_kind_o;
  logic [7:0]  ack_vec_o, eoi_bcast_vec_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  vec_prio_ctrl uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid_i(req_valid_i), .req_vec_i(req_vec_i), .req_level_i(req_level_i),
    .tpr_wr_i(tpr_wr_i), .tpr_data_i(tpr_data_i),
    .ctl_wr_i(ctl_wr_i), .ctl_data_i(ctl_data_i),
    .ack_req_i(ack_req_i), .eoi_wr_i(eoi_wr_i),
    .irq_o(irq_o), .ack_done_o(ack_done_o), .ack_kind_o(ack_kind_o),
    .ack_vec_o(ack_vec_o), .eoi_bcast_o(eoi_bcast_o),
    .eoi_bcast_vec_o(eoi_bcast_vec_o));

  task automatic chk(input string tag, input bit ok, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit [255:0] m_irr, m_isr, m_tmr;
  int m_tpr, m_spur;
  bit m_en, m_supp;
  bit e_irq, e_done, e_bc;
  int e_kind, e_vec, e_bcv;

  function automatic int top_of(bit [255:0] a);
    for (int i = 255; i >= 0; i--) if (a[i]) return i;
    return -1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_irr = '0; m_isr = '0; m_tmr = '0;
      m_tpr = 0; m_spur = 255; m_en = 0; m_supp = 0;
      e_irq = 0; e_done = 0; e_kind = 0; e_vec = 0; e_bc = 0; e_bcv = 0;
    end else begin
      int it, st, st2, cls, ppr;
      bit blk, gr, bl;
      bit [255:0] told;
      it  = top_of(m_irr);
      st  = top_of(m_isr);
      cls = (st < 0) ? 0 : st / 16;
      ppr = ((m_tpr / 16) >= cls) ? m_tpr : cls * 16;
      blk = (ppr != 0) && ((it / 16) <= (ppr / 16));
      gr  = m_en && (it >= 0) && !blk;
      bl  = m_en && (it >= 0) && blk;
      told = m_tmr;
      e_irq  = gr;
      e_done = ack_req_i;
      e_kind = !ack_req_i ? 0 : gr ? 1 : bl ? 2 : 0;
      e_vec  = (ack_req_i && gr) ? it : (ack_req_i && bl) ? m_spur : 0;
      if (ack_req_i && gr) begin m_irr[it] = 0; m_isr[it] = 1; end
      if (req_valid_i) begin m_irr[req_vec_i] = 1; m_tmr[req_vec_i] = req_level_i; end
      e_bc = 0; e_bcv = 0;
      st2 = top_of(m_isr);
      if (eoi_wr_i && st2 >= 0) begin
        m_isr[st2] = 0;
        e_bc  = told[st2] && !m_supp;
        e_bcv = e_bc ? st2 : 0;
      end
      if (tpr_wr_i) m_tpr = tpr_data_i;
      if (ctl_wr_i) begin
        m_spur = ctl_data_i[7:0]; m_en = ctl_data_i[8]; m_supp = ctl_data_i[12];
      end
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R5 irq vs model", irq_o == e_irq, irq_o, e_irq);
      chk(e_kind == 1 ? "R6 ack vs model" : e_kind == 2 ? "R7 ack vs model" : "R8 ack vs model",
          ack_done_o == e_done && ack_kind_o == 2'(e_kind) && ack_vec_o == 8'(e_vec),
          {ack_done_o, ack_kind_o, ack_vec_o}, {e_done, 2'(e_kind), 8'(e_vec)});
      chk("R10 bcast vs model", eoi_bcast_o == e_bc && eoi_bcast_vec_o == 8'(e_bcv),
          {eoi_bcast_o, eoi_bcast_vec_o}, {e_bc, 8'(e_bcv)});
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic send(input logic [7:0] v, input logic lvl);
    req_valid_i = 1; req_vec_i = v; req_level_i = lvl;
    @(negedge clk);
    req_valid_i = 0;
  endtask

  task automatic wr_tpr(input logic [7:0] v);
    tpr_wr_i = 1; tpr_data_i = v;
    @(negedge clk);
    tpr_wr_i = 0;
  endtask

  task automatic wr_ctl(input logic [31:0] v);
    ctl_wr_i = 1; ctl_data_i = v;
    @(negedge clk);
    ctl_wr_i = 0;
  endtask

  task automatic do_ack(input string tag, input logic [1:0] k, input logic [7:0] v);
    ack_req_i = 1;
    @(negedge clk);
    ack_req_i = 0;
    chk(tag, ack_done_o && ack_kind_o == k && ack_vec_o == v,
        {ack_kind_o, ack_vec_o}, {k, v});
  endtask

  task automatic do_eoi(input string tag, input logic bc, input logic [7:0] v);
    eoi_wr_i = 1;
    @(negedge clk);
    eoi_wr_i = 0;
    chk(tag, eoi_bcast_o == bc && (!bc || eoi_bcast_vec_o == v),
        {eoi_bcast_o, eoi_bcast_vec_o}, {bc, v});
  endtask

  task automatic chk_irq(input string tag, input logic exp);
    @(negedge clk);
    chk(tag, irq_o == exp, irq_o, exp);
  endtask

  // watchdog
  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 20000 && !finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 irq low", irq_o == 0, irq_o, 0);
    chk("R1 ack idle", ack_done_o == 0, ack_done_o, 0);
    chk("R1 bcast idle", eoi_bcast_o == 0, eoi_bcast_o, 0);
    do_ack("R1 disabled after reset", 2'b00, 8'h00);
    send(8'h40, 0);
    chk_irq("R8 disabled no irq", 0);
    do_ack("R8 disabled answers none", 2'b00, 8'h00);
    // R11 enable with junk in ignored bits
    wr_ctl(32'h5A5A_E1F3);
    chk_irq("R11 enable raises irq", 1);
    do_ack("R6 first vector", 2'b01, 8'h40);
    chk_irq("R6 irq drops when taken", 0);
    // nesting and same-class blocking
    send(8'h41, 0);
    chk_irq("R5 same class blocked", 0);
    do_ack("R7 spurious vector", 2'b10, 8'hF3);
    send(8'h40, 0);
    send(8'h75, 1);
    send(8'h72, 0);
    chk_irq("R5 higher class raises", 1);
    do_ack("R3 highest pending", 2'b01, 8'h75);
    do_ack("R7 class 7 blocked by 75", 2'b10, 8'hF3);
    do_eoi("R10 level retire broadcasts", 1, 8'h75);
    do_ack("R9 priority drops after retire", 2'b01, 8'h72);
    do_eoi("R10 edge retire silent", 0, 8'h00);
    do_ack("R7 pending 40 vs in-service 40", 2'b10, 8'hF3);
    do_eoi("R9 retire 40", 0, 8'h00);
    do_ack("R3 41 before 40", 2'b01, 8'h41);
    do_ack("R4 lower while 41 in service", 2'b10, 8'hF3);
    do_eoi("R9 retire 41", 0, 8'h00);
    do_ack("R6 40 again", 2'b01, 8'h40);
    do_eoi("R9 retire 40 again", 0, 8'h00);
    do_eoi("R9 empty no effect", 0, 8'h00);
    do_ack("R8 nothing pending", 2'b00, 8'h00);
    // task priority masking
    wr_tpr(8'h5A);
    send(8'h55, 0);
    chk_irq("R4 tpr class masks 55", 0);
    do_ack("R4 tpr masked spurious", 2'b10, 8'hF3);
    send(8'h60, 0);
    chk_irq("R4 class 6 above tpr", 1);
    do_ack("R4 take 60", 2'b01, 8'h60);
    wr_tpr(8'h80);
    send(8'h90, 1);
    do_ack("R4 take 90 above tpr 80", 2'b01, 8'h90);
    wr_ctl(32'h0000_11F3);
    do_eoi("R11 suppression blocks broadcast", 0, 8'h00);
    do_eoi("R9 retire 60", 0, 8'h00);
    wr_tpr(8'h00);
    do_ack("R4 55 after tpr clear", 2'b01, 8'h55);
    do_eoi("R9 retire 55", 0, 8'h00);
    wr_ctl(32'h0000_01F3);
    // R12 same-cycle ordering
    send(8'h30, 1);
    ack_req_i = 1; eoi_wr_i = 1;
    @(negedge clk);
    ack_req_i = 0; eoi_wr_i = 0;
    chk("R12 ack before eoi", ack_kind_o == 2'b01 && ack_vec_o == 8'h30,
        {ack_kind_o, ack_vec_o}, {2'b01, 8'h30});
    chk("R12 eoi retires acked vector", eoi_bcast_o && eoi_bcast_vec_o == 8'h30,
        {eoi_bcast_o, eoi_bcast_vec_o}, {1'b1, 8'h30});
    do_ack("R12 sets empty after", 2'b00, 8'h00);
    send(8'h33, 0);
    req_valid_i = 1; req_vec_i = 8'h33; req_level_i = 0; ack_req_i = 1;
    @(negedge clk);
    req_valid_i = 0; ack_req_i = 0;
    chk("R12 ack with same-vector request", ack_kind_o == 2'b01 && ack_vec_o == 8'h33,
        {ack_kind_o, ack_vec_o}, {2'b01, 8'h33});
    do_ack("R12 re-request stays pending", 2'b10, 8'hF3);
    do_eoi("R9 retire 33", 0, 8'h00);
    do_ack("R12 33 again", 2'b01, 8'h33);
    do_eoi("R9 retire 33 again", 0, 8'h00);
    // R2 trigger type overwrite
    send(8'hA0, 1);
    send(8'hA0, 0);
    do_ack("R2 take A0", 2'b01, 8'hA0);
    do_eoi("R2 edge overwrite silences", 0, 8'h00);
    send(8'hA1, 1);
    do_ack("R2 take A1", 2'b01, 8'hA1);
    do_eoi("R2 level broadcasts", 1, 8'hA1);
    // zero processor priority admits class 0
    send(8'h05, 0);
    do_ack("R4 class 0 with zero priority", 2'b01, 8'h05);
    send(8'h03, 0);
    do_ack("R4 nested class 0", 2'b01, 8'h03);
    do_eoi("R9 retire 05 first", 0, 8'h00);
    do_eoi("R9 retire 03", 0, 8'h00);
    // disable while pending
    send(8'h20, 0);
    wr_ctl(32'h0000_00F3);
    chk_irq("R8 disabled drops irq", 0);
    do_ack("R8 disabled with pending", 2'b00, 8'h00);
    wr_ctl(32'h0000_01F3);
    chk_irq("R11 re-enable", 1);
    do_ack("R6 take 20", 2'b01, 8'h20);
    repeat (3) @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule